// File: doc/BRIEF.md
# Multi-Lane SPI Result Serializer

This block sits on the target side of a chip-select-framed SPI link and shifts a 22-bit conversion result out to a host. The host frames each read with an active-low select. It clocks the serial clock in one of four polarity/phase modes and reads the result over one, two or four data lanes. An optional early-launch setting moves every bit group after the first half a serial-clock period ahead of standard timing. Once the word is exhausted, the lanes carry zeros. A status output is high while the link is idle and low for the whole frame.

The select and serial clock are asynchronous to the block. They are synchronised into a faster system clock, and their edges are detected there. The word and the three configuration fields (clock mode, lane width, output mode) are captured when select falls. A frame therefore reads one consistent snapshot, and a raised select ends the frame at any point.

Top module: `spi_ro_serializer`

## Requirements
- R1: While reset is asserted, and right after it is released, every lane is 0 and the idle strobe `rvs` is 1.
- R2: With `cs_n` high, all lanes are 0 and `rvs` is 1. Throughout a frame (`cs_n` low), `rvs` is 0.
- R3: Lane width code 00 (single) sends one bit per launch on lane 0, MSB first (bit 21 first), and lanes 1 to 3 stay 0.
- R4: Lane width code 10 (dual) sends two bits per launch in 11 groups. Lane 1 carries the more significant bit of each group, and lanes 2 and 3 stay 0.
- R5: Lane width code 11 (quad) sends four bits per launch, with lane 3 carrying the most significant bit of each group. The word takes 6 groups. The last group holds bits 1 and 0 on lanes 3 and 2, and zeros on lanes 1 and 0.
- R6: Clock mode bit 1 gives the serial-clock idle level (0 = low, 1 = high). The host captures on the rising edge in modes 00 and 11 and on the falling edge in modes 01 and 10. In modes 00 and 10 the first group is driven when `cs_n` falls, and each later group is driven on the non-capture edge.
- R7: In modes 01 and 11 the lanes stay 0 after `cs_n` falls until the first leading serial-clock edge (rising in 01, falling in 11). That edge drives the first group, and every later leading edge drives the next group.
- R8: Output mode code 01 in clock modes 00 and 10 drives each group after the first on the capture edge, half a period earlier than standard timing.
- R9: Output mode code 01 has no effect in clock modes 01 and 11.
- R10: Clock edges after the last group drive 0 on every lane.
- R11: Raising `cs_n` mid-frame clears the lanes at once. The next frame starts from bit 21 of the word present at its own `cs_n` fall.
- R12: Changes to the data word or the configuration fields while `cs_n` is low do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select from the host (asynchronous) |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| data_word | input | DATA_W | Result word to transmit |
| clk_mode | input | 2 | Polarity/phase mode |
| lane_sel | input | 2 | Lane width: 00 single, 10 dual, 11 quad |
| out_mode | input | 2 | Output mode: 01 selects early launch |
| sdo | output | LANES | Serial data lanes, lane LANES-1 most significant |
| rvs | output | 1 | Idle strobe: high between frames, low in a frame |

## Verification
The hardest situation to observe from the ports is the half-period shift of early launch. A host that samples only on its capture edge reads the same word whether early launch is on or off. The bench therefore samples the lanes before both edges of every serial-clock period. The sample taken just before the non-capture edge must already hold the next group under early launch, and must still hold the current group without it. That single sample point separates R8 from R9 and from standard timing. A mid-frame abort with the word and width changed under an active select shows R11 and R12 together.

// File: rtl/spi_ro_pkg.sv
package spi_ro_pkg;

  typedef enum logic [1:0] {
    LW_ONE  = 2'b00,
    LW_RSV  = 2'b01,
    LW_TWO  = 2'b10,
    LW_FOUR = 2'b11
  } lane_w_e;

  localparam logic [1:0] OM_EARLY = 2'b01;

  // Bits per launch for a width code; the reserved code acts as single lane.
  function automatic int lanes_of(lane_w_e w);
    case (w)
      LW_TWO:  return 2;
      LW_FOUR: return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/spi_ro_edge_sync.sv
module spi_ro_edge_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {(STAGES+1){INIT}};
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/spi_ro_lane_fmt.sv
module spi_ro_lane_fmt
  import spi_ro_pkg::*;
#(
  parameter int SH_W  = 24,
  parameter int LANES = 4
) (
  input  logic [SH_W-1:0]  src,
  input  lane_w_e          width,
  output logic [LANES-1:0] grp
);
  localparam int IW = $clog2(SH_W);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic          bit_q;
    logic [IW-1:0] idx;
    always_comb begin
      idx   = IW'(SH_W - lanes_of(width) + i);
      bit_q = 1'b0;
      if (i < lanes_of(width)) bit_q = src[idx];
    end
    assign grp[i] = bit_q;
  end
endmodule

// File: rtl/spi_ro_serializer.sv
module spi_ro_serializer
  import spi_ro_pkg::*;
#(
  parameter int DATA_W      = 22,
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] data_word,
  input  logic [1:0]        clk_mode,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        out_mode,
  output logic [LANES-1:0]  sdo,
  output logic              rvs
);
  localparam int SH_W = ((DATA_W + LANES - 1) / LANES) * LANES;
  localparam int PAD  = SH_W - DATA_W;

  logic cs_lvl, cs_rise, cs_fall;
  logic sc_lvl, sclk_rise, sclk_fall;

  spi_ro_edge_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .din(cs_n),
    .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
  );

  spi_ro_edge_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sclk_sync (
    .clk(clk), .rst(rst), .din(sclk),
    .level(sc_lvl), .rise(sclk_rise), .fall(sclk_fall)
  );

  // Frame state captured at select fall
  logic            in_frame;
  logic [1:0]      mode_q;
  lane_w_e         width_q;
  logic            edl_q;
  logic [SH_W-1:0] shreg;
  logic [LANES-1:0] sdo_q;
  logic            rvs_q;

  logic            launch_on_rise;
  logic            launch_ev, capture_ev, shift_ev;
  logic [SH_W-1:0] aligned, fmt_src, shifted;
  lane_w_e         fmt_w;
  logic [LANES-1:0] fmt_grp;

  // Launch edge is rising for modes 01/10, falling for 00/11
  assign launch_on_rise = mode_q[0] ^ mode_q[1];
  assign launch_ev  = in_frame & (launch_on_rise ? sclk_rise : sclk_fall);
  assign capture_ev = in_frame & (launch_on_rise ? sclk_fall : sclk_rise);
  assign shift_ev   = edl_q ? capture_ev : launch_ev;

  assign aligned = {data_word, {PAD{1'b0}}};
  assign fmt_src = cs_fall ? aligned : shreg;
  assign fmt_w   = cs_fall ? lane_w_e'(lane_sel) : width_q;
  assign shifted = fmt_src << lanes_of(fmt_w);

  spi_ro_lane_fmt #(.SH_W(SH_W), .LANES(LANES)) u_fmt (
    .src(fmt_src), .width(fmt_w), .grp(fmt_grp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      mode_q   <= 2'b00;
      width_q  <= LW_ONE;
      edl_q    <= 1'b0;
      shreg    <= '0;
      sdo_q    <= '0;
      rvs_q    <= 1'b1;
    end else if (cs_rise) begin
      in_frame <= 1'b0;
      sdo_q    <= '0;
      rvs_q    <= 1'b1;
    end else if (cs_fall) begin
      in_frame <= 1'b1;
      rvs_q    <= 1'b0;
      mode_q   <= clk_mode;
      width_q  <= lane_w_e'(lane_sel);
      edl_q    <= (out_mode == OM_EARLY) && !clk_mode[0];
      if (!clk_mode[0]) begin
        sdo_q <= fmt_grp;
        shreg <= shifted;
      end else begin
        sdo_q <= '0;
        shreg <= aligned;
      end
    end else if (shift_ev) begin
      sdo_q <= fmt_grp;
      shreg <= shifted;
    end
  end

  assign sdo = sdo_q;
  assign rvs = rvs_q;

  logic unused_lvl;
  assign unused_lvl = cs_lvl ^ sc_lvl;
endmodule

// File: rtl/spi_ro_serializer_chk.sv
module spi_ro_serializer_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic [LANES-1:0] sdo,
  input logic             rvs,
  input logic [1:0]       width_q,
  input logic [1:0]       mode_q,
  input logic             edl_q,
  input logic             shift_ev,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic             cs_fall,
  input logic             cs_rise
);
  logic [2:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= cs_n  ? ((hi_cnt == 3'd7) ? hi_cnt : hi_cnt + 3'd1) : 3'd0;
      lo_cnt <= !cs_n ? ((lo_cnt == 3'd7) ? lo_cnt : lo_cnt + 3'd1) : 3'd0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt >= 3'd4) |-> (sdo == '0) && rvs); // R2
  AST_FRAME_STROBE_LOW: assert property (@(posedge clk) disable iff (rst)
    (lo_cnt >= 3'd4) |-> !rvs); // R2
  AST_SINGLE_MASK: assert property (@(posedge clk) disable iff (rst)
    (width_q[1] == 1'b0) |-> (sdo[LANES-1:1] == '0)); // R3
  AST_DUAL_MASK: assert property (@(posedge clk) disable iff (rst)
    (width_q == 2'b10) |-> (sdo[LANES-1:2] == '0)); // R4
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !(shift_ev || cs_fall || cs_rise) |=> $stable(sdo)); // R6
  AST_EARLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (edl_q && shift_ev) |-> (mode_q[1] ? sclk_fall : sclk_rise)); // R8
  AST_EARLY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (mode_q[0] && shift_ev) |-> (mode_q[1] ? sclk_fall : sclk_rise)); // R9
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> (sdo == '0)); // R11
endmodule

bind spi_ro_serializer spi_ro_serializer_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdo(sdo), .rvs(rvs),
  .width_q(width_q), .mode_q(mode_q), .edl_q(edl_q), .shift_ev(shift_ev),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .cs_fall(cs_fall), .cs_rise(cs_rise)
);

// File: tb/spi_ro_serializer_test.sv
module spi_ro_serializer_test;
  localparam int H = 8;   // system clocks per serial half period

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [21:0] data_word = '0;
  logic [1:0]  clk_mode = 2'b00, lane_sel = 2'b00, out_mode = 2'b00;
  logic [3:0]  sdo;
  logic        rvs;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_ro_serializer uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .data_word(data_word),
    .clk_mode(clk_mode), .lane_sel(lane_sel), .out_mode(out_mode),
    .sdo(sdo), .rvs(rvs)
  );

  task automatic chk(string req, logic [21:0] act, logic [21:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  // Group p of word w at wid lanes; top lane holds the most significant bit
  function automatic logic [3:0] grp(logic [21:0] w, int wid, int p);
    logic [3:0] g;
    g = '0;
    if (p < 0) return g;
    for (int i = 0; i < wid; i++) begin
      int idx;
      idx = 21 - p * wid - (wid - 1 - i);
      if (idx >= 0) g[i] = w[idx];
    end
    return g;
  endfunction

  function automatic string tag_of(logic [1:0] m, int wid, bit edl, int p, int ng, bit second);
    if (p >= ng) return "R10 zero fill";
    if (p == 0 && !second) return m[0] ? "R7 quiet before first launch" : "R6 first group at select fall";
    if (edl) return m[0] ? "R9 early launch ignored" : "R8 early launch";
    return (wid == 4) ? "R5 quad group" : (wid == 2) ? "R4 dual group" : "R3 single group";
  endfunction

  task automatic run_frame(logic [1:0] m, logic [1:0] lw, bit edl, logic [21:0] w);
    int wid, ng, nper;
    bit early;
    logic [21:0] rec;
    logic [3:0] s, e;
    wid   = (lw == 2'b11) ? 4 : (lw == 2'b10) ? 2 : 1;
    ng    = (22 + wid - 1) / wid;
    nper  = ng + 2;
    early = edl && !m[0];
    rec   = '0;
    clk_mode = m; lane_sel = lw; out_mode = edl ? 2'b01 : 2'b00;
    data_word = w; sclk = m[1];
    half();
    chk("R2 idle lanes", 22'(sdo), 22'd0);
    chk("R2 idle strobe high", 22'(rvs), 22'd1);
    cs_n = 1'b0;
    half();
    chk("R2 strobe low in frame", 22'(rvs), 22'd0);
    for (int p = 0; p < nper; p++) begin
      s = sdo;
      e = m[0] ? grp(w, wid, p - 1) : grp(w, wid, p);
      chk(tag_of(m, wid, edl, p, ng, 1'b0), 22'(s), 22'(e));
      if (!m[0] && p < ng)
        for (int i = 0; i < wid; i++) begin
          int idx;
          idx = 21 - p * wid - (wid - 1 - i);
          if (idx >= 0) rec[idx] = s[i];
        end
      sclk = ~sclk;
      half();
      s = sdo;
      e = m[0] ? grp(w, wid, p) : (early ? grp(w, wid, p + 1) : grp(w, wid, p));
      chk(tag_of(m, wid, edl, p, ng, 1'b1), 22'(s), 22'(e));
      if (m[0] && p < ng)
        for (int i = 0; i < wid; i++) begin
          int idx;
          idx = 21 - p * wid - (wid - 1 - i);
          if (idx >= 0) rec[idx] = s[i];
        end
      sclk = ~sclk;
      half();
    end
    chk((wid == 4) ? "R5 word rebuilt" : (wid == 2) ? "R4 word rebuilt" : "R3 word rebuilt", rec, w);
    cs_n = 1'b1;
    half();
    chk("R2 lanes cleared after frame", 22'(sdo), 22'd0);
    chk("R2 strobe high after frame", 22'(rvs), 22'd1);
  endtask

  task automatic test_reset();
    repeat (6) @(negedge clk);
    chk("R1 lanes in reset", 22'(sdo), 22'd0);
    chk("R1 strobe in reset", 22'(rvs), 22'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 lanes after reset", 22'(sdo), 22'd0);
    chk("R1 strobe after reset", 22'(rvs), 22'd1);
  endtask

  // R12 word/width changes mid-frame ignored; R11 abort then fresh start
  task automatic test_abort();
    logic [21:0] a, b;
    a = 22'h3A5F0C; b = 22'h0C3E71;
    clk_mode = 2'b00; lane_sel = 2'b00; out_mode = 2'b00; data_word = a; sclk = 1'b0;
    half();
    cs_n = 1'b0;
    half();
    for (int p = 0; p < 5; p++) begin
      chk("R12 frame keeps latched word and width", 22'(sdo), 22'(grp(a, 1, p)));
      if (p == 1) begin
        data_word = b; lane_sel = 2'b11; clk_mode = 2'b01; out_mode = 2'b01;
      end
      sclk = 1'b1; half();
      sclk = 1'b0; half();
    end
    cs_n = 1'b1;
    half();
    chk("R11 abort clears lanes", 22'(sdo), 22'd0);
    chk("R11 abort raises strobe", 22'(rvs), 22'd1);
    run_frame(2'b00, 2'b11, 1'b0, b);   // R11 restart from MSB of new word
  endtask

  initial begin : main
    logic [21:0] words [4];
    int k;
    words[0] = 22'h3FFFFF; words[1] = 22'h200001;
    words[2] = 22'h2C6B1D; words[3] = 22'h15A4E2;
    test_reset();
    k = 0;
    for (int m = 0; m < 4; m++)
      for (int wsel = 0; wsel < 3; wsel++)
        for (int edl = 0; edl < 2; edl++) begin
          logic [1:0] lw;
          lw = (wsel == 0) ? 2'b00 : (wsel == 1) ? 2'b10 : 2'b11;
          run_frame(2'(m), lw, edl[0], words[k % 4] ^ 22'(k * 22'h01F0E1));
          k++;
        end
    test_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule